// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle it takes a 4-bit operation code, a first operand (normally a register value) and a second operand (normally the output of a barrel shifter), and produces a result. It also produces a destination write-enable and the next value of the four condition flags: negative, zero, carry and overflow. The result, the write-enable and the next-flag value are combinational. The flags themselves are held in a small register that loads on the rising clock edge only when the set-flags input is high.

Carry-consuming operations (add-with-carry, subtract-with-carry, reverse-subtract-with-carry) take their incoming carry from the stored flag register. Subtractions treat carry as "no borrow". The four compare and test codes compute a value and may update the flags, but they never request a register write. A 32-bit status word is formed by placing the stored flags in the top four bits above a 28-bit control value supplied from outside.

Top module: `dp_alu`

## Requirements
- R1: Opcode 0 gives A AND B, 1 gives A XOR B, 12 gives A OR B, 13 gives B, 14 gives A AND NOT B, and 15 gives NOT B, on `result_o`.
- R2: Opcode 4 (add) gives A+B, and opcode 5 (add with carry) gives A+B+C, where C is the stored carry. With set-flags high, C is set on unsigned carry out of bit 31, and V is set when both addends share a sign that the result does not.
- R3: Opcode 2 (subtract) gives A−B. With set-flags high, C is 1 exactly when A ≥ B unsigned, and V is bit 31 of (A XOR B) AND (A XOR result).
- R4: Opcode 6 (subtract with carry) gives A−B+C−1. Its carry out is A > B when C was 0, and A ≥ B when C was 1. Its V follows the signed overflow of that full expression.
- R5: Opcode 3 gives B−A, and opcode 7 gives B−A+C−1. Their flags follow the R3 and R4 rules with the operands exchanged.
- R6: For logical opcodes (0, 1, 8, 9, 12–15) with set-flags high, N is result bit 31, Z is set when the result is zero, C takes `shift_carry_i`, and V keeps its stored value.
- R7: Opcodes 8 (AND test), 9 (XOR test), 10 (compare, A−B) and 11 (compare-negative, A+B) drive `wr_en_o` low and follow the flag rules of their underlying operation. Every other opcode drives `wr_en_o` high.
- R8: `flags_o` (N bit 3, Z bit 2, C bit 1, V bit 0) takes `flags_next_o` at a rising clock edge when `set_flags_i` is high, and otherwise holds its value.
- R9: `status_o` carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28 from the stored flags, and `ctrl_i` unchanged in bits 27:0.
- R10: While `rst_n` is low, the stored flags are all zero.
- R11: With `set_flags_i` low, `flags_next_o` equals `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (shifter output) |
| set_flags_i | input | 1 | Update the flags with this operation |
| shift_carry_i | input | 1 | Shifter carry-out, used as C by logical operations |
| ctrl_i | input | 28 | Control bits placed in the low part of the status word |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write-enable |
| flags_next_o | output | 4 | Flags this operation would store, {N,Z,C,V} |
| flags_o | output | 4 | Stored flags, {N,Z,C,V} |
| status_o | output | 32 | Packed status word |

## Verification
Two things share one cycle. The flag register loads on an edge, and in the same cycle the result of the next operation is formed from the carry that was just stored. A back-to-back chain of carry-consuming operations with set-flags high therefore reads a carry written one edge earlier. The bench provokes this with long random runs and directed pairs, such as a subtract with A < B followed by a subtract-with-carry with A equal to B. It judges every cycle against a reference model that keeps its own copy of the flags, so one wrong carry shows up in the next result.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_RSC = 4'd7,
        OP_TST = 4'd8,
        OP_TEQ = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MOV = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic op_is_arith(input alu_op_e op);
        unique case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic op_writes(input alu_op_e op);
        unique case (op)
            OP_TST, OP_TEQ, OP_CMP, OP_CMN: return 1'b0;
            default:                        return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);

    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              ovf_o
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic              cin;
    logic [SUM_W-1:0]  sum;

    // Subtracts are done as lhs + ~rhs + cin, so carry out means "no borrow".
    always_comb begin
        unique case (op_i)
            OP_SUB, OP_CMP: begin lhs = a_i; rhs = ~b_i; cin = 1'b1;    end
            OP_RSB:         begin lhs = b_i; rhs = ~a_i; cin = 1'b1;    end
            OP_SBC:         begin lhs = a_i; rhs = ~b_i; cin = carry_i; end
            OP_RSC:         begin lhs = b_i; rhs = ~a_i; cin = carry_i; end
            OP_ADC:         begin lhs = a_i; rhs = b_i;  cin = carry_i; end
            default:        begin lhs = a_i; rhs = b_i;  cin = 1'b0;    end
        endcase
    end

    assign sum     = {1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
    assign res_o   = sum[DATA_W-1:0];
    assign carry_o = sum[DATA_W];
    assign ovf_o   = (lhs[DATA_W-1] == rhs[DATA_W-1]) &&
                     (sum[DATA_W-1] != lhs[DATA_W-1]);

endmodule

// File: rtl/dp_alu_flagreg.sv
module dp_alu_flagreg
    import dp_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  flags_t next_i,
    output flags_t q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= next_i;
        end
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = DATA_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              set_flags_i,
    input  logic              shift_carry_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_next_o,
    output logic [3:0]        flags_o,
    output logic [DATA_W-1:0] status_o
);

    alu_op_e           op;
    flags_t            cur;
    flags_t            calc;
    flags_t            nxt;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] arith_res;
    logic              arith_c;
    logic              arith_v;
    logic              is_arith;

    assign op       = alu_op_e'(op_i);
    assign is_arith = op_is_arith(op);

    dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (logic_res)
    );

    dp_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op_i    (op),
        .a_i     (a_i),
        .b_i     (b_i),
        .carry_i (cur.c),
        .res_o   (arith_res),
        .carry_o (arith_c),
        .ovf_o   (arith_v)
    );

    always_comb begin
        result_o = is_arith ? arith_res : logic_res;
        calc.n   = result_o[DATA_W-1];
        calc.z   = (result_o == '0);
        calc.c   = is_arith ? arith_c : shift_carry_i;
        calc.v   = is_arith ? arith_v : cur.v;
        nxt      = set_flags_i ? calc : cur;
    end

    dp_alu_flagreg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (set_flags_i),
        .next_i (nxt),
        .q_o    (cur)
    );

    assign wr_en_o      = op_writes(op);
    assign flags_next_o = nxt;
    assign flags_o      = cur;
    assign status_o     = {cur, ctrl_i};

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = DATA_W - 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              set_flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [3:0]        flags_next_o,
    input logic [3:0]        flags_o,
    input logic [DATA_W-1:0] status_o
);

    logic is_logical;
    assign is_logical = (op_i < 4'd2) || (op_i == 4'd8) || (op_i == 4'd9) || (op_i >= 4'd12);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> $stable(flags_o));

    assert_flag_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> (flags_o == $past(flags_next_o)));

    assert_next_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |-> (flags_next_o == flags_o));

    assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && (op_i == 4'd2)) |-> (flags_next_o[1] == (a_i >= b_i)));

    assert_logic_v_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && is_logical) |-> (flags_next_o[0] == flags_o[0]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |-> (flags_next_o[2] == (result_o == '0)));

    assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] == 2'b10) |-> !wr_en_o);

    assert_status_pack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[DATA_W-1 -: 4] == flags_o);

endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .a_i          (a_i),
    .b_i          (b_i),
    .set_flags_i  (set_flags_i),
    .result_o     (result_o),
    .wr_en_o      (wr_en_o),
    .flags_next_o (flags_next_o),
    .flags_o      (flags_o),
    .status_o     (status_o)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        set_flags_i = 1'b0;
    logic        shift_carry_i = 1'b0;
    logic [27:0] ctrl_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_next_o;
    logic [3:0]  flags_o;
    logic [31:0] status_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] mflags = '0;

    always #2 clk = ~clk;

    dp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .set_flags_i(set_flags_i), .shift_carry_i(shift_carry_i), .ctrl_i(ctrl_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_next_o(flags_next_o),
        .flags_o(flags_o), .status_o(status_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (op %0d a %h b %h)", tag, act, exp, op_i, a_i, b_i);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd8, 4'd9, 4'd10, 4'd11: return "R7";
            4'd2:                     return "R3";
            4'd3, 4'd7:               return "R5";
            4'd4, 4'd5:               return "R2";
            4'd6:                     return "R4";
            default:                  return "R1_R6";
        endcase
    endfunction

    // {carry, overflow, result} of x - y - (k ? 0 : 1)
    function automatic logic [33:0] ref_sub(input logic [31:0] x, input logic [31:0] y, input logic k);
        longint s;
        logic [31:0] r;
        logic c;
        logic v;
        r = x - y - (k ? 32'd0 : 32'd1);
        c = k ? (x >= y) : (x > y);
        s = longint'($signed(x)) - longint'($signed(y)) - (k ? 64'sd0 : 64'sd1);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return {c, v, r};
    endfunction

    function automatic logic [33:0] ref_add(input logic [31:0] x, input logic [31:0] y, input logic k);
        longint unsigned u;
        longint s;
        u = longint'(x) + longint'(y) + (k ? 64'd1 : 64'd0);
        s = longint'($signed(x)) + longint'($signed(y)) + (k ? 64'sd1 : 64'sd0);
        return {u[32], (s > 64'sd2147483647) || (s < -64'sd2147483648), u[31:0]};
    endfunction

    // returns {wr, flags_next[3:0], result[31:0]}
    function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                          input logic [3:0] fl, input logic sc, input logic sf);
        logic [33:0] t;
        logic [31:0] r;
        logic c;
        logic v;
        logic [3:0] nf;
        c = sc;
        v = fl[0];
        r = '0;
        case (op)
            4'd0, 4'd8: r = a & b;
            4'd1, 4'd9: r = a ^ b;
            4'd12:      r = a | b;
            4'd13:      r = b;
            4'd14:      r = a & ~b;
            4'd15:      r = ~b;
            default: begin
                case (op)
                    4'd2, 4'd10: t = ref_sub(a, b, 1'b1);
                    4'd3:        t = ref_sub(b, a, 1'b1);
                    4'd6:        t = ref_sub(a, b, fl[1]);
                    4'd7:        t = ref_sub(b, a, fl[1]);
                    4'd5:        t = ref_add(a, b, fl[1]);
                    default:     t = ref_add(a, b, 1'b0);
                endcase
                {c, v, r} = t;
            end
        endcase
        nf = sf ? {r[31], r == 32'd0, c, v} : fl;
        return {!(op >= 4'd8 && op <= 4'd11), nf, r};
    endfunction

    task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic sf, input logic sc);
        logic [36:0] e;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; set_flags_i = sf; shift_carry_i = sc;
        ctrl_i = 28'($urandom);
        #1;
        e = model(op, a, b, mflags, sc, sf);
        check(tag_of(op), result_o, e[31:0]);
        check(op >= 4'd8 && op <= 4'd11 ? "R7" : "R7_write", 32'(wr_en_o), 32'(e[36]));
        check(sf ? tag_of(op) : "R11", 32'(flags_next_o), 32'(e[35:32]));
        check("R9", status_o, {mflags, ctrl_i});
        @(posedge clk);
        #1;
        if (sf) mflags = e[35:32];
        check("R8", 32'(flags_o), 32'(mflags));
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R10", 32'(flags_o), 32'd0);
        check("R10", 32'(status_o[31:28]), 32'd0);
        rst_n = 1'b1;

        // directed corners
        step(4'd2, 32'd5, 32'd5, 1'b1, 1'b0);                  // R3 equal: C=1 Z=1
        step(4'd2, 32'd3, 32'd9, 1'b1, 1'b0);                  // R3 borrow: C=0 N=1
        step(4'd6, 32'd7, 32'd7, 1'b1, 1'b0);                  // R4 carry in 0, A==B -> C=0
        step(4'd6, 32'd7, 32'd7, 1'b1, 1'b0);                  // R4 carry in from previous
        step(4'd4, 32'h7fffffff, 32'd1, 1'b1, 1'b0);           // R2 signed overflow
        step(4'd4, 32'hffffffff, 32'd1, 1'b1, 1'b0);           // R2 carry out, zero
        step(4'd5, 32'd10, 32'd20, 1'b1, 1'b0);                // R2 add with carry
        step(4'd3, 32'd1, 32'd8, 1'b1, 1'b0);                  // R5 reverse subtract
        step(4'd7, 32'd1, 32'd8, 1'b1, 1'b0);                  // R5 reverse with carry
        step(4'd2, 32'h80000000, 32'd1, 1'b1, 1'b0);           // R3 overflow
        step(4'd13, 32'd0, 32'd0, 1'b1, 1'b1);                 // R6 MOV zero, C from shifter
        step(4'd15, 32'd0, 32'd0, 1'b1, 1'b0);                 // R6 MVN negative
        step(4'd10, 32'd4, 32'd4, 1'b1, 1'b0);                 // R7 compare equal
        step(4'd8, 32'hf0, 32'h0f, 1'b1, 1'b1);                // R7 test zero
        step(4'd11, 32'hffffffff, 32'd1, 1'b0, 1'b0);          // R11 compare without set
        step(4'd0, 32'h0, 32'h0, 1'b0, 1'b1);                  // R8 hold

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom;
            b = $urandom;
            if (($urandom % 8) == 0) b = a;
            if (($urandom % 8) == 0) a = {$urandom % 2 == 0, 31'h7fffffff};
            step(4'($urandom), a, b, 1'($urandom % 4 != 0), 1'($urandom));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule